// File: doc/BRIEF.md
# Port Access Permission Checker

This block decides whether a 1-, 2- or 4-byte port access may proceed, based on a permission bitmap kept in a task segment in memory. A start pulse captures the segment descriptor (present flag, 4-bit type, base, limit), the port number and the access size. The checker first validates the descriptor. It then reads the bitmap pointer stored inside the segment, and then reads the two bitmap bytes that cover the port. It ends with a one-cycle done pulse that carries either allow or fault.

A fault stands for a general-protection fault whose error code is always zero, so no separate code output is needed. Memory is reached over a simple port: the checker drives a one-cycle request with an address and waits for a read-valid strobe with 16 bits of data. Latency is unbounded.

Top module: `io_perm_check`

## Requirements
- R1: The descriptor is usable only when the present flag is 1, the type equals 4'd9 and the limit is 103 or more. Otherwise done and fault are high in the cycle after start, and no memory request is issued.
- R2: For a usable descriptor, mem_req is high in the cycle after start with mem_addr = base + 0x66. The 16-bit data returned is the bitmap pointer.
- R3: The byte index is pointer + (port >> 3). If index + 1 is greater than the limit, done and fault are high in the cycle after the pointer data arrives, and no second request is made. Index + 1 equal to the limit is accepted.
- R4: Otherwise a second request reads address base + index. The returned word is little-endian: bits 7:0 come from address base + index and bits 15:8 from base + index + 1. The word is shifted right by port[2:0].
- R5: The shifted word is masked by (1 << size) - 1, with size equal to 1, 2 or 4. The access is allowed only if every masked bit is zero, even when the window crosses into the second byte.
- R6: done is a one-cycle pulse. allow and fault are high only together with done, and exactly one of them is high. A final result comes the cycle after the bitmap data arrives.
- R7: Read data is taken on mem_rvalid in any cycle after the request cycle, so any latency of one or more cycles works.
- R8: A start pulse that arrives while a check is in progress is ignored and does not change that check's result.
- R9: A synchronous active-high reset returns the checker to idle with done, allow, fault and mem_req low. A read-valid that arrives after the reset is ignored.
- R10: mem_req is a one-cycle pulse, issued at most twice per check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches a check while idle |
| seg_present | input | 1 | Descriptor present flag |
| seg_type | input | 4 | Descriptor type field |
| seg_base | input | ADDR_W | Segment base address |
| seg_limit | input | LIM_W | Segment limit (last valid byte offset) |
| port_num | input | PORT_W | Port number being accessed |
| acc_size | input | 3 | Access width in bytes: 1, 2 or 4 |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Byte address of the 16-bit read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data, little-endian |
| done | output | 1 | Result pulse |
| allow | output | 1 | Access permitted (with done) |
| fault | output | 1 | General-protection fault, error code zero (with done) |

## Verification
The hardest case to reach from the ports is a second start, or a reset, that lands while the checker is waiting on memory. The bench model stretches the read latency over several cycles. It pulses start with an invalid descriptor inside that wait, and in a separate run it asserts reset and then delivers a stray read-valid. Straddling windows come from ports whose low three bits push a 2- or 4-bit mask past bit 7, with a blocking bit placed only in the upper byte. Both the exact limit boundary and the boundary plus one are run.

// File: rtl/io_perm_check.sv
module io_perm_check #(
  parameter int ADDR_W = 32,
  parameter int LIM_W = 32,
  parameter int PORT_W = 16,
  parameter int PTR_OFF = 'h66,
  parameter int MIN_LIM = 103,
  parameter logic [3:0] SEG_TYPE = 4'd9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              seg_present,
  input  logic [3:0]        seg_type,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [LIM_W-1:0]  seg_limit,
  input  logic [PORT_W-1:0] port_num,
  input  logic [2:0]        acc_size,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata,
  output logic              done,
  output logic              allow,
  output logic              fault
);
  localparam int IDX_W = ((PORT_W - 3) > 16 ? (PORT_W - 3) : 16) + 1;
  localparam int CMP_W = (IDX_W > LIM_W ? IDX_W : LIM_W) + 1;

  typedef enum logic [1:0] {S_IDLE, S_PTR, S_MAP} st_t;
  st_t st;

  logic [ADDR_W-1:0] base_q;
  logic [LIM_W-1:0]  lim_q;
  logic [PORT_W-1:0] port_q;
  logic [2:0]        size_q;

  wire desc_ok = seg_present && (seg_type == SEG_TYPE) && (seg_limit >= LIM_W'(MIN_LIM));
  wire take    = mem_rvalid && !mem_req;

  wire [IDX_W-1:0] idx_nx = IDX_W'(mem_rdata) + IDX_W'(port_q >> 3);
  wire over = (CMP_W'(idx_nx) + CMP_W'(1)) > CMP_W'(lim_q);

  wire [7:0] win  = 8'(mem_rdata >> port_q[2:0]);
  wire [7:0] mask = (8'd1 << size_q) - 8'd1;
  wire blocked = |(win & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      allow    <= 1'b0;
      fault    <= 1'b0;
      base_q   <= '0;
      lim_q    <= '0;
      port_q   <= '0;
      size_q   <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      allow   <= 1'b0;
      fault   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q <= seg_base;
          lim_q  <= seg_limit;
          port_q <= port_num;
          size_q <= acc_size;
          if (!desc_ok) begin
            done  <= 1'b1;
            fault <= 1'b1;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= seg_base + ADDR_W'(PTR_OFF);
            st       <= S_PTR;
          end
        end
        S_PTR: if (take) begin
          if (over) begin
            done  <= 1'b1;
            fault <= 1'b1;
            st    <= S_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= base_q + ADDR_W'(idx_nx);
            st       <= S_MAP;
          end
        end
        S_MAP: if (take) begin
          done  <= 1'b1;
          allow <= !blocked;
          fault <= blocked;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  desc_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && !desc_ok) |=> (done && fault && !mem_req));

  // R2
  ptr_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && desc_ok) |=>
      (mem_req && mem_addr == $past(seg_base) + ADDR_W'(PTR_OFF)));

  // R6
  result_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (allow || fault) |-> (done && $onehot({allow, fault})));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && start && !mem_rvalid) |=> !done);
endmodule

// File: tb/io_perm_check_tb.sv
`timescale 1ns/1ps
module io_perm_check_tb;
  logic clk = 0;
  logic rst = 1;
  logic start = 0;
  logic seg_present = 0;
  logic [3:0] seg_type = 0;
  logic [31:0] seg_base = 0;
  logic [31:0] seg_limit = 0;
  logic [15:0] port_num = 0;
  logic [2:0] acc_size = 0;
  logic mem_req;
  logic [31:0] mem_addr;
  logic mem_rvalid = 0;
  logic [15:0] mem_rdata = 0;
  logic done, allow, fault;

  int total = 0;
  int fails = 0;
  logic [7:0] mem [0:1023];

  always #2.5 clk = ~clk;

  io_perm_check u_dut (
    .clk(clk), .rst(rst), .start(start), .seg_present(seg_present),
    .seg_type(seg_type), .seg_base(seg_base), .seg_limit(seg_limit),
    .port_num(port_num), .acc_size(acc_size), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .allow(allow), .fault(fault)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet(input string tag);
    check(done == 0 && allow == 0 && fault == 0 && mem_req == 0, tag,
          {done, allow, fault, mem_req}, 0);
  endtask

  task automatic serve(input int addr, input int lat, input bit poke);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      start = 0;
      seg_present = 1;
      quiet("R7 wait");
      if (poke && i == 0) begin
        start = 1;
        seg_present = 0;
      end
    end
    start = 0;
    seg_present = 1;
    mem_rvalid = 1;
    mem_rdata = {mem[addr + 1], mem[addr]};
    @(negedge clk);
    mem_rvalid = 0;
  endtask

  task automatic run(input bit pres, input logic [3:0] typ, input int base, input int lim,
                     input int port, input int size, input int lat, input bit poke,
                     input string tag);
    bit good;
    int ptr, idx, exp_allow;
    int word;
    good = pres && typ == 4'd9 && lim >= 103;
    @(negedge clk);
    seg_present = pres; seg_type = typ; seg_base = base; seg_limit = lim;
    port_num = port; acc_size = size[2:0]; start = 1;
    @(negedge clk);
    start = 0;
    if (!good) begin
      check(done && fault && !allow && !mem_req, {tag, " R1 early fault"},
            {done, allow, fault, mem_req}, 4'b1010);
      @(negedge clk);
      quiet({tag, " R6 pulse"});
      return;
    end
    check(mem_req && mem_addr == base + 'h66, {tag, " R2 pointer read"}, mem_addr, base + 'h66);
    serve(base + 'h66, lat, poke);
    ptr = {mem[base + 'h67], mem[base + 'h66]};
    idx = ptr + (port >> 3);
    if (idx + 1 > lim) begin
      check(done && fault && !allow && !mem_req, {tag, " R3 limit fault"},
            {done, allow, fault, mem_req}, 4'b1010);
      @(negedge clk);
      quiet({tag, " R6 pulse"});
      return;
    end
    check(mem_req && !done && mem_addr == base + idx, {tag, " R4 bitmap read"}, mem_addr, base + idx);
    serve(base + idx, lat, 1'b0);
    word = {mem[base + idx + 1], mem[base + idx]};
    exp_allow = ((word >> (port & 7)) & ((1 << size) - 1)) == 0;
    check(done && !mem_req && allow == exp_allow[0] && fault == !exp_allow[0],
          {tag, " R5 result"}, {done, allow, fault}, {1'b1, exp_allow[0], !exp_allow[0]});
    @(negedge clk);
    quiet({tag, " R6 pulse"});
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
    mem['h66] = 8'h80; mem['h67] = 8'h00;
    mem['h80] = 8'b0000_0100;
    mem['h83] = 8'h01;
    mem['h166] = 8'h40; mem['h167] = 8'h00;
    mem['h140] = 8'hFF;

    repeat (3) @(negedge clk);
    quiet("R9 reset state");
    rst = 0;
    @(negedge clk);
    quiet("R9 idle after reset");

    run(0, 4'd9, 0, 'h1FF, 0, 1, 1, 0, "R1 not present");
    run(1, 4'hB, 0, 'h1FF, 0, 1, 1, 0, "R1 wrong type");
    run(1, 4'd9, 0, 102, 0, 1, 1, 0, "R1 limit 102");
    run(1, 4'd9, 0, 103, 0, 1, 1, 0, "R3 limit 103");
    run(1, 4'd9, 0, 'h1FF, 0, 1, 1, 0, "R5 port0 b1");
    run(1, 4'd9, 0, 'h1FF, 2, 1, 2, 0, "R5 port2 b1");
    run(1, 4'd9, 0, 'h1FF, 1, 2, 1, 0, "R5 port1 b2");
    run(1, 4'd9, 0, 'h1FF, 3, 4, 3, 0, "R5 port3 b4");
    run(1, 4'd9, 0, 'h1FF, 'h17, 1, 1, 0, "R4 straddle b1");
    run(1, 4'd9, 0, 'h1FF, 'h17, 2, 1, 0, "R4 straddle b2");
    run(1, 4'd9, 0, 'h1FF, 'h14, 4, 1, 0, "R5 port14 b4");
    run(1, 4'd9, 0, 'h1FF, 'h16, 4, 1, 0, "R4 straddle b4");
    run(1, 4'd9, 0, 'h89, 'h40, 1, 1, 0, "R3 index+1 eq limit");
    run(1, 4'd9, 0, 'h88, 'h40, 1, 1, 0, "R3 index+1 over limit");
    run(1, 4'd9, 'h100, 'h200, 5, 1, 7, 0, "R7 long latency seg2");
    run(1, 4'd9, 'h100, 'h200, 8, 1, 5, 0, "R7 seg2 allow");
    run(1, 4'd9, 0, 'h1FF, 2, 1, 4, 1, "R8 start while busy");
    run(1, 4'd9, 0, 'h1FF, 0, 1, 4, 1, "R8 start while busy allow");

    @(negedge clk);
    seg_present = 1; seg_type = 4'd9; seg_base = 0; seg_limit = 'h1FF;
    port_num = 2; acc_size = 1; start = 1;
    @(negedge clk);
    start = 0;
    check(mem_req == 1, "R10 request before reset", mem_req, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    quiet("R9 reset mid-check");
    mem_rvalid = 1; mem_rdata = 16'h0080;
    @(negedge clk);
    mem_rvalid = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      quiet("R9 stray rvalid ignored");
    end
    run(1, 4'd9, 0, 'h1FF, 0, 1, 2, 0, "R9 check after reset");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule